// File: doc/BRIEF.md
# Keyboard Scancode Translator (AT set 2 to XT)

This block converts the byte stream received from an AT-style keyboard into the byte stream an XT-style keyboard transmitter expects. Each received byte is either a scancode (bit 7 clear) or a command code (bit 7 set). Scancodes are looked up in a small table and forwarded as XT make codes. The release prefix 0xF0 is absorbed and arms a release flag. The next scancode then leaves as a single XT break code, which is the make code with bit 7 set. Other command codes, such as acknowledge (0xFA) and resend (0xFE), are swallowed.

Both sides use valid/ready. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the single output holding register is empty, so a busy transmitter stalls the keyboard side. Once `out_valid` rises, it stays high and `out_data` stays frozen until a clock edge that also sees `out_ready` high. The translation takes one cycle: an accepted scancode with a table entry appears on the output after the same clock edge.

Top module: `kbd_code_xlat`

## Requirements
- R1: An accepted byte with bit 7 set never produces an output byte. After the edge that takes it, `out_valid` is low.
- R2: The byte 0xF0 arms the release flag. Any other byte with bit 7 set (for example 0xFA or 0xFE) produces no output and leaves the release flag as it was.
- R3: An accepted scancode with a table entry, while the flag is clear, produces one output byte equal to its XT code. The table (incoming, outgoing, hex) is: A 1C→1E, B 32→30, C 21→2E, D 23→20, E 24→12, F 2B→21, G 34→22, H 33→23, I 43→17, J 3B→24, K 42→25, L 4B→26, M 3A→32, N 31→31, O 44→18, P 4D→19, Q 15→10, R 2D→13, S 1B→1F, T 2C→14, U 3C→16, V 2A→2F, W 1D→11, X 22→2D, Y 35→15, Z 1A→2C, space 29→39.
- R4: An accepted scancode (bit 7 clear) that has no table entry produces no output.
- R5: An accepted scancode with a table entry, while the flag is armed, produces exactly one output byte equal to its XT code OR 0x80.
- R6: Any accepted scancode clears the release flag, whether or not it has a table entry.
- R7: `in_ready` is high exactly when the holding register is empty. While the register is full, no byte is taken.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R9: Reset (`rst_n` low) clears `out_valid` and the release flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received keyboard byte is offered |
| in_data | input | 8 | Received keyboard byte |
| in_ready | output | 1 | The block takes the offered byte on this edge |
| out_valid | output | 1 | An XT byte is waiting |
| out_data | output | 8 | XT byte to transmit |
| out_ready | input | 1 | The transmitter takes the waiting byte |

## Verification
The embedded assertions check the following on every cycle:
- a command byte is followed by an empty output register;
- 0xF0 arms the release flag;
- any scancode clears the flag;
- an output produced while the flag was armed carries bit 7;
- a stalled output holds its value.

The bench's scenarios are needed for the rest:
- the table contents, swept over all 128 scancodes both as presses and as releases;
- that unmapped codes are dropped;
- that non-0xF0 commands keep an armed flag intact;
- the stall-then-resume handshake ordering.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = BYTE_W - 1;
  localparam logic [BYTE_W-1:0] REL_PREFIX = 8'hF0;

  typedef enum logic [1:0] {
    KIND_SCAN   = 2'd0,
    KIND_RELPFX = 2'd1,
    KIND_CMD    = 2'd2
  } byte_kind_e;

  function automatic byte_kind_e classify(input logic [BYTE_W-1:0] b);
    if (!b[BYTE_W-1])     return KIND_SCAN;
    if (b == REL_PREFIX)  return KIND_RELPFX;
    return KIND_CMD;
  endfunction
endpackage

// File: rtl/xlat_lut.sv
module xlat_lut
  import xlat_pkg::*;
(
  input  logic [CODE_W-1:0] at_code,
  output logic              hit,
  output logic [CODE_W-1:0] xt_code
);
  always_comb begin
    hit     = 1'b1;
    xt_code = '0;
    unique case (at_code)
      7'h1C: xt_code = 7'h1E;
      7'h32: xt_code = 7'h30;
      7'h21: xt_code = 7'h2E;
      7'h23: xt_code = 7'h20;
      7'h24: xt_code = 7'h12;
      7'h2B: xt_code = 7'h21;
      7'h34: xt_code = 7'h22;
      7'h33: xt_code = 7'h23;
      7'h43: xt_code = 7'h17;
      7'h3B: xt_code = 7'h24;
      7'h42: xt_code = 7'h25;
      7'h4B: xt_code = 7'h26;
      7'h3A: xt_code = 7'h32;
      7'h31: xt_code = 7'h31;
      7'h44: xt_code = 7'h18;
      7'h4D: xt_code = 7'h19;
      7'h15: xt_code = 7'h10;
      7'h2D: xt_code = 7'h13;
      7'h1B: xt_code = 7'h1F;
      7'h2C: xt_code = 7'h14;
      7'h3C: xt_code = 7'h16;
      7'h2A: xt_code = 7'h2F;
      7'h1D: xt_code = 7'h11;
      7'h22: xt_code = 7'h2D;
      7'h35: xt_code = 7'h15;
      7'h1A: xt_code = 7'h2C;
      7'h29: xt_code = 7'h39;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              emit,
  output logic [BYTE_W-1:0] emit_byte,
  output logic              rel_armed
);
  byte_kind_e          kind;
  logic                lut_hit;
  logic [CODE_W-1:0]   lut_code;

  assign kind = classify(rx_byte);

  xlat_lut u_lut (
    .at_code (rx_byte[CODE_W-1:0]),
    .hit     (lut_hit),
    .xt_code (lut_code)
  );

  assign emit      = take && (kind == KIND_SCAN) && lut_hit;
  assign emit_byte = {rel_armed, lut_code};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_armed <= 1'b0;
    end else if (take) begin
      unique case (kind)
        KIND_RELPFX: rel_armed <= 1'b1;
        KIND_SCAN:   rel_armed <= 1'b0;
        default:     rel_armed <= rel_armed;
      endcase
    end
  end

  // R2: the release prefix arms the flag
  assert_prefix_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rx_byte == REL_PREFIX) |=> rel_armed);

  // R6: every scancode consumes the flag
  assert_scan_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rx_byte[BYTE_W-1]) |=> !rel_armed);
endmodule

// File: rtl/xlat_outreg.sv
module xlat_outreg
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              empty,
  output logic              q_valid,
  output logic [BYTE_W-1:0] q_byte,
  input  logic              q_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_byte  <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_byte  <= load_byte;
    end else if (q_valid && q_ready) begin
      q_valid <= 1'b0;
    end
  end

  assign empty = !q_valid;

  // R8: a stalled byte holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_byte)));
endmodule

// File: rtl/kbd_code_xlat.sv
module kbd_code_xlat
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  logic              take;
  logic              emit;
  logic [BYTE_W-1:0] emit_byte;
  logic              rel_armed;
  logic              hold_empty;

  assign in_ready = hold_empty;
  assign take     = in_valid && hold_empty;

  xlat_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .rx_byte   (in_data),
    .emit      (emit),
    .emit_byte (emit_byte),
    .rel_armed (rel_armed)
  );

  xlat_outreg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (emit),
    .load_byte (emit_byte),
    .empty     (hold_empty),
    .q_valid   (out_valid),
    .q_byte    (out_data),
    .q_ready   (out_ready)
  );

  // R1: command bytes leave the output register empty
  assert_cmd_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_data[BYTE_W-1]) |=> !out_valid);

  // R5: a scancode taken while armed yields nothing or a break code
  assert_break_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_data[BYTE_W-1] && rel_armed) |=> (!out_valid || out_data[BYTE_W-1]));
endmodule

// File: tb/tb_kbd_code_xlat.sv
module tb_kbd_code_xlat;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  kbd_code_xlat dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  // reference table from R3, returns 8'hFF when unmapped
  function automatic logic [7:0] ref_xt(input logic [6:0] c);
    case (c)
      7'h1C: return 8'h1E; 7'h32: return 8'h30; 7'h21: return 8'h2E;
      7'h23: return 8'h20; 7'h24: return 8'h12; 7'h2B: return 8'h21;
      7'h34: return 8'h22; 7'h33: return 8'h23; 7'h43: return 8'h17;
      7'h3B: return 8'h24; 7'h42: return 8'h25; 7'h4B: return 8'h26;
      7'h3A: return 8'h32; 7'h31: return 8'h31; 7'h44: return 8'h18;
      7'h4D: return 8'h19; 7'h15: return 8'h10; 7'h2D: return 8'h13;
      7'h1B: return 8'h1F; 7'h2C: return 8'h14; 7'h3C: return 8'h16;
      7'h2A: return 8'h2F; 7'h1D: return 8'h11; 7'h22: return 8'h2D;
      7'h35: return 8'h15; 7'h1A: return 8'h2C; 7'h29: return 8'h39;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // observe the output one cycle after acceptance, then drain it
  task automatic expect_out(input bit exp_v, input logic [7:0] exp_d, input string req);
    check(out_valid == exp_v, req, {8'h0, out_valid}, {8'h0, exp_v});
    if (exp_v && out_valid) check(out_data == exp_d, req, {1'b0, out_data}, {1'b0, exp_d});
    if (out_valid) begin
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] e;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid after reset", {8'h0, out_valid}, 9'h0);
    check(in_ready == 1'b1, "R7 in_ready when empty", {8'h0, in_ready}, 9'h1);
    rst_n = 1'b1;
    push(8'h1C);
    expect_out(1'b1, 8'h1E, "R9 flag clear after reset, A press");

    // R3/R4: every scancode as a press
    for (int c = 0; c < 128; c++) begin
      e = ref_xt(7'(c));
      push(8'(c));
      expect_out(e != 8'hFF, e, (e != 8'hFF) ? "R3 press map" : "R4 unmapped dropped");
    end

    // R5/R6: every scancode as a release, then a press to show the flag cleared
    for (int c = 0; c < 128; c++) begin
      e = ref_xt(7'(c));
      push(8'hF0);
      expect_out(1'b0, 8'h00, "R2 prefix silent");
      push(8'(c));
      expect_out(e != 8'hFF, e | 8'h80, (e != 8'hFF) ? "R5 break code" : "R4 unmapped release dropped");
      push(8'h1C);
      expect_out(1'b1, 8'h1E, "R6 flag cleared after scancode");
    end

    // R1: every command byte other than the prefix is silent
    for (int b = 128; b < 256; b++) begin
      if (b != 8'hF0) begin
        push(8'(b));
        expect_out(1'b0, 8'h00, "R1 command silent");
      end
    end

    // R2: other commands keep an armed flag
    push(8'hF0); expect_out(1'b0, 8'h00, "R2 prefix silent");
    push(8'hFA); expect_out(1'b0, 8'h00, "R2 ack silent");
    push(8'hFE); expect_out(1'b0, 8'h00, "R2 resend silent");
    push(8'h1C); expect_out(1'b1, 8'h9E, "R2 flag kept across commands");
    push(8'hF0); expect_out(1'b0, 8'h00, "R2 prefix silent");
    push(8'hF0); expect_out(1'b0, 8'h00, "R2 double prefix silent");
    push(8'h32); expect_out(1'b1, 8'hB0, "R2 double prefix one break");
    push(8'h32); expect_out(1'b1, 8'h30, "R6 flag cleared");

    // R7/R8: stall with output pending
    push(8'h1C);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h32;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7 no accept while full", {8'h0, in_ready}, 9'h0);
      check(out_valid && out_data == 8'h1E, "R8 hold while stalled", {1'b0, out_data}, 9'h1E);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7 ready after drain", {8'h0, in_ready}, 9'h1);
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(1'b1, 8'h30, "R7 stalled byte taken after drain");

    // R9: reset mid-release clears the flag and output
    push(8'hF0);
    push(8'h1C);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 reset drops output", {8'h0, out_valid}, 9'h0);
    push(8'hF0);
    rst_n = 1'b1;
    push(8'h1C);
    expect_out(1'b1, 8'h1E, "R9 reset clears release flag");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule